// File: doc/BRIEF.md
# Cylinder/Head/Sector Address Stepper

This block keeps the disk address of a multi-sector transfer up to date. An initialise pulse captures the emulated drive geometry from the task-file fields. The count field gives the sectors per track. The head field gives the highest head index. The cylinder field gives the number of cylinders. A start pulse then loads the starting sector, head, cylinder and sector count from the same fields, and the transfer becomes busy.

Each sector-done pulse from the media engine moves the address to the next sector in cylinder/head/sector order and decrements the remaining count. The block flags the final sector, pulses a done output after it, and stops with an out-of-range flag if the address would run past the last cylinder. An error or command-end input stops the transfer with the address left on the sector being processed. Media access and any translation to physical geometry happen outside this block.

Top module: `chs_stepper`

## Requirements
- R1: After reset: sector_o = 1, head_o = 0, cyl_o = 0, remain_o = 0, and busy_o, last_o, done_o and range_err_o are all low.
- R2: A start pulse loads tf_sector_i, tf_head_i and tf_cyl_i into the address, loads tf_count_i into remain_o, and sets busy_o. A count field of 0 loads 256.
- R3: While busy, a sector_done pulse that is not the last one and stays inside the geometry increments sector_o by one and decrements remain_o by one.
- R4: When sector_o equals the sectors-per-track value, the step sets sector_o to 1 and increments head_o. A count field of 0 at initialise means 256 sectors per track.
- R5: When head_o also equals the head field captured at initialise (the highest head index), the step sets head_o to 0 and increments cyl_o.
- R6: If a step would move past cylinder (cylinder count − 1), the step raises range_err_o, clears busy_o, and leaves the address and remain_o unchanged. A cylinder count of 0 means 65536.
- R7: last_o is high while busy and remain_o = 1. A sector_done pulse in that state leaves the address unchanged, sets remain_o to 0, clears busy_o, and raises done_o for exactly one cycle on the next edge.
- R8: err_i or cmd_end_i while busy clears busy_o and holds the address and remain_o. A sector_done pulse in the same cycle is not counted.
- R9: An initialise pulse while busy is ignored. The geometry used by later transfers is unchanged.
- R10: A sector_done pulse while not busy changes no output.
- R11: A start pulse clears range_err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Capture geometry from the task-file fields |
| start_i | input | 1 | Load start address and count, begin transfer |
| sec_done_i | input | 1 | One sector processed |
| err_i | input | 1 | Transfer failed; freeze |
| cmd_end_i | input | 1 | Command ended; freeze |
| tf_count_i | input | 8 | Sector count, or sectors per track at initialise |
| tf_sector_i | input | 8 | Starting sector number |
| tf_head_i | input | 4 | Starting head, or highest head index at initialise |
| tf_cyl_i | input | 16 | Starting cylinder, or cylinder count at initialise |
| sector_o | output | 9 | Current sector number (1-based) |
| head_o | output | 4 | Current head |
| cyl_o | output | 16 | Current cylinder |
| remain_o | output | 9 | Sectors still to transfer |
| last_o | output | 1 | Current sector is the final one |
| done_o | output | 1 | One-cycle pulse after the final sector |
| busy_o | output | 1 | Transfer in progress |
| range_err_o | output | 1 | Address ran past the last cylinder |

## Verification
The stepping checks assume that a start loads an address inside the current geometry. The sector must lie between 1 and the sectors per track, the head must not exceed the highest head index, and the cylinder must be below the cylinder count. The stimulus only starts transfers from addresses that satisfy this. The sweep runs every legal start address of a geometry with three sectors, two heads and three cylinders, with counts from 1 to 4. Expected addresses come from a linear sector index, so transfers that reach the last cylinder hit the range error. A separate geometry with the 256-sector encoding covers the zero-means-maximum cases.

// File: rtl/chs_pkg.sv
package chs_pkg;
  parameter int unsigned SEC_W_D  = 8;
  parameter int unsigned HEAD_W_D = 4;
  parameter int unsigned CYL_W_D  = 16;
  parameter int unsigned CNT_W_D  = 8;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_ADV  = 2'd1,
    STEP_LAST = 2'd2,
    STEP_OVF  = 2'd3
  } step_e;
endpackage

// File: rtl/chs_geom.sv
module chs_geom #(
  parameter int unsigned SEC_W  = chs_pkg::SEC_W_D,
  parameter int unsigned HEAD_W = chs_pkg::HEAD_W_D,
  parameter int unsigned CYL_W  = chs_pkg::CYL_W_D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [SEC_W-1:0]  spt_i,
  input  logic [HEAD_W-1:0] hmax_i,
  input  logic [CYL_W-1:0]  ncyl_i,
  output logic [SEC_W:0]    spt_last_o,
  output logic [HEAD_W-1:0] head_last_o,
  output logic [CYL_W-1:0]  cyl_last_o
);
  localparam logic [SEC_W:0] SPT_FULL = {1'b1, {SEC_W{1'b0}}};

  logic [SEC_W:0]    spt_q, spt_d;
  logic [HEAD_W-1:0] hl_q, hl_d;
  logic [CYL_W-1:0]  cl_q, cl_d;

  always_comb begin
    spt_d = spt_q;
    hl_d  = hl_q;
    cl_d  = cl_q;
    if (load_i) begin
      spt_d = (spt_i == '0) ? SPT_FULL : {1'b0, spt_i};
      hl_d  = hmax_i;
      cl_d  = ncyl_i - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spt_q <= SPT_FULL;
      hl_q  <= '1;
      cl_q  <= '1;
    end else begin
      spt_q <= spt_d;
      hl_q  <= hl_d;
      cl_q  <= cl_d;
    end
  end

  assign spt_last_o  = spt_q;
  assign head_last_o = hl_q;
  assign cyl_last_o  = cl_q;
endmodule

// File: rtl/chs_count.sv
module chs_count #(
  parameter int unsigned CNT_W = chs_pkg::CNT_W_D
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             dec_i,
  output logic [CNT_W:0]   remain_o,
  output logic             last_o
);
  localparam logic [CNT_W:0] CNT_FULL = {1'b1, {CNT_W{1'b0}}};

  logic [CNT_W:0] rem_q, rem_d;

  always_comb begin
    rem_d = rem_q;
    if (load_i)     rem_d = (cnt_i == '0) ? CNT_FULL : {1'b0, cnt_i};
    else if (dec_i) rem_d = rem_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rem_q <= '0;
    else        rem_q <= rem_d;
  end

  assign remain_o = rem_q;
  assign last_o   = (rem_q == {{CNT_W{1'b0}}, 1'b1});

  // R3
  cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_i && !load_i |=> remain_o == $past(remain_o) - 1'b1);
endmodule

// File: rtl/chs_addr.sv
module chs_addr #(
  parameter int unsigned SEC_W  = chs_pkg::SEC_W_D,
  parameter int unsigned HEAD_W = chs_pkg::HEAD_W_D,
  parameter int unsigned CYL_W  = chs_pkg::CYL_W_D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [SEC_W-1:0]  sec_i,
  input  logic [HEAD_W-1:0] head_i,
  input  logic [CYL_W-1:0]  cyl_i,
  input  logic              adv_i,
  input  logic [SEC_W:0]    spt_last_i,
  input  logic [HEAD_W-1:0] head_last_i,
  input  logic [CYL_W-1:0]  cyl_last_i,
  output logic [SEC_W:0]    sec_o,
  output logic [HEAD_W-1:0] head_o,
  output logic [CYL_W-1:0]  cyl_o,
  output logic              carry_o
);
  localparam logic [SEC_W:0] SEC_FIRST = {{SEC_W{1'b0}}, 1'b1};

  logic [SEC_W:0]    sec_q, sec_d;
  logic [HEAD_W-1:0] head_q, head_d;
  logic [CYL_W-1:0]  cyl_q, cyl_d;
  logic              sec_wrap, head_wrap;

  assign sec_wrap  = (sec_q == spt_last_i);
  assign head_wrap = sec_wrap && (head_q == head_last_i);
  assign carry_o   = head_wrap && (cyl_q == cyl_last_i);

  always_comb begin
    sec_d  = sec_q;
    head_d = head_q;
    cyl_d  = cyl_q;
    if (load_i) begin
      sec_d  = {1'b0, sec_i};
      head_d = head_i;
      cyl_d  = cyl_i;
    end else if (adv_i) begin
      sec_d = sec_wrap ? SEC_FIRST : sec_q + 1'b1;
      if (sec_wrap)  head_d = head_wrap ? '0 : head_q + 1'b1;
      if (head_wrap) cyl_d  = cyl_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= SEC_FIRST;
      head_q <= '0;
      cyl_q  <= '0;
    end else begin
      sec_q  <= sec_d;
      head_q <= head_d;
      cyl_q  <= cyl_d;
    end
  end

  assign sec_o  = sec_q;
  assign head_o = head_q;
  assign cyl_o  = cyl_q;

  // R3
  sec_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i && !load_i && !sec_wrap |=> sec_o == $past(sec_o) + 1'b1 && $stable(head_o) && $stable(cyl_o));
  // R4
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i && !load_i && sec_wrap |=> sec_o == SEC_FIRST);
  // R5
  head_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i && !load_i && head_wrap |=> head_o == '0 && cyl_o == $past(cyl_o) + 1'b1);
endmodule

// File: rtl/chs_stepper.sv
module chs_stepper #(
  parameter int unsigned SEC_W  = chs_pkg::SEC_W_D,
  parameter int unsigned HEAD_W = chs_pkg::HEAD_W_D,
  parameter int unsigned CYL_W  = chs_pkg::CYL_W_D,
  parameter int unsigned CNT_W  = chs_pkg::CNT_W_D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_i,
  input  logic              start_i,
  input  logic              sec_done_i,
  input  logic              err_i,
  input  logic              cmd_end_i,
  input  logic [CNT_W-1:0]  tf_count_i,
  input  logic [SEC_W-1:0]  tf_sector_i,
  input  logic [HEAD_W-1:0] tf_head_i,
  input  logic [CYL_W-1:0]  tf_cyl_i,
  output logic [SEC_W:0]    sector_o,
  output logic [HEAD_W-1:0] head_o,
  output logic [CYL_W-1:0]  cyl_o,
  output logic [CNT_W:0]    remain_o,
  output logic              last_o,
  output logic              done_o,
  output logic              busy_o,
  output logic              range_err_o
);
  import chs_pkg::*;

  logic              busy_q, busy_d, rerr_q, rerr_d, done_q;
  logic              geo_load, cnt_last, carry, accept;
  logic [SEC_W:0]    spt_last;
  logic [HEAD_W-1:0] head_last;
  logic [CYL_W-1:0]  cyl_last;
  step_e             step;

  assign geo_load = init_i && !busy_q;
  assign accept   = busy_q && sec_done_i && !err_i && !cmd_end_i && !start_i;

  always_comb begin
    if (!accept)       step = STEP_NONE;
    else if (cnt_last) step = STEP_LAST;
    else if (carry)    step = STEP_OVF;
    else               step = STEP_ADV;
  end

  chs_geom #(.SEC_W(SEC_W), .HEAD_W(HEAD_W), .CYL_W(CYL_W)) u_geom (
    .clk(clk), .rst_n(rst_n), .load_i(geo_load),
    .spt_i(tf_count_i), .hmax_i(tf_head_i), .ncyl_i(tf_cyl_i),
    .spt_last_o(spt_last), .head_last_o(head_last), .cyl_last_o(cyl_last)
  );

  chs_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .load_i(start_i), .cnt_i(tf_count_i),
    .dec_i(step == STEP_ADV || step == STEP_LAST),
    .remain_o(remain_o), .last_o(cnt_last)
  );

  chs_addr #(.SEC_W(SEC_W), .HEAD_W(HEAD_W), .CYL_W(CYL_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load_i(start_i),
    .sec_i(tf_sector_i), .head_i(tf_head_i), .cyl_i(tf_cyl_i),
    .adv_i(step == STEP_ADV),
    .spt_last_i(spt_last), .head_last_i(head_last), .cyl_last_i(cyl_last),
    .sec_o(sector_o), .head_o(head_o), .cyl_o(cyl_o), .carry_o(carry)
  );

  always_comb begin
    busy_d = busy_q;
    rerr_d = rerr_q;
    if (start_i) begin
      busy_d = 1'b1;
      rerr_d = 1'b0;
    end else if (err_i || cmd_end_i || step == STEP_LAST) begin
      busy_d = 1'b0;
    end else if (step == STEP_OVF) begin
      busy_d = 1'b0;
      rerr_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rerr_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      rerr_q <= rerr_d;
      done_q <= (step == STEP_LAST);
    end
  end

  assign busy_o      = busy_q;
  assign range_err_o = rerr_q;
  assign done_o      = done_q;
  assign last_o      = busy_q && cnt_last;

  // R2
  busy_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> remain_o != '0);
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o && remain_o == '0 && !$past(done_o));
  // R6
  range_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(range_err_o) |-> !busy_o && $stable(cyl_o) && $stable(remain_o));
  // R8
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && (err_i || cmd_end_i) && !start_i |=> !busy_o && $stable(sector_o) && $stable(head_o) && $stable(cyl_o) && $stable(remain_o));
  // R9
  init_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && init_i |=> $stable(spt_last) && $stable(head_last) && $stable(cyl_last));
  // R10
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && !start_i |=> $stable(sector_o) && $stable(head_o) && $stable(cyl_o) && $stable(remain_o));
endmodule

// File: tb/tb_chs_stepper.sv
module tb_chs_stepper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init_i = 0, start_i = 0, sec_done_i = 0, err_i = 0, cmd_end_i = 0;
  logic [7:0]  tf_count_i = 0, tf_sector_i = 0;
  logic [3:0]  tf_head_i = 0;
  logic [15:0] tf_cyl_i = 0;
  logic [8:0]  sector_o, remain_o;
  logic [3:0]  head_o;
  logic [15:0] cyl_o;
  logic        last_o, done_o, busy_o, range_err_o;

  int checks = 0, fails = 0;
  bit finished = 0;

  chs_stepper dut (.*);

  always #10 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_init(int spt, int hmax, int ncyl);
    @(negedge clk);
    tf_count_i = spt[7:0]; tf_head_i = hmax[3:0]; tf_cyl_i = ncyl[15:0]; init_i = 1;
    @(negedge clk);
    init_i = 0;
  endtask

  task automatic pulse_start(int s, int h, int c, int n);
    @(negedge clk);
    tf_sector_i = s[7:0]; tf_head_i = h[3:0]; tf_cyl_i = c[15:0]; tf_count_i = n[7:0]; start_i = 1;
    @(negedge clk);
    start_i = 0;
  endtask

  task automatic step();
    @(negedge clk); sec_done_i = 1;
    @(negedge clk); sec_done_i = 0;
  endtask

  task automatic chk_addr(string req, int idx);
    chk(req, int'(sector_o), idx % 3 + 1);
    chk(req, int'(head_o), (idx / 3) % 2);
    chk(req, int'(cyl_o), idx / 6);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", int'(sector_o), 1);  chk("R1", int'(head_o), 0);
    chk("R1", int'(cyl_o), 0);     chk("R1", int'(remain_o), 0);
    chk("R1", int'(busy_o), 0);    chk("R1", int'(last_o), 0);
    chk("R1", int'(done_o), 0);    chk("R1", int'(range_err_o), 0);
    rst_n = 1;

    // Sweep: 3 sectors/track, heads 0..1, 3 cylinders (18 sectors)
    pulse_init(3, 1, 3);
    for (int c = 0; c < 3; c++)
      for (int h = 0; h < 2; h++)
        for (int s = 1; s <= 3; s++)
          for (int n = 1; n <= 4; n++) begin
            int base;
            base = (c * 2 + h) * 3 + (s - 1);
            pulse_start(s, h, c, n);
            chk("R2", int'(remain_o), n);
            chk("R2", int'(busy_o), 1);
            chk("R7", int'(last_o), (n == 1) ? 1 : 0);
            chk_addr("R2", base);
            for (int i = 1; i <= n; i++) begin
              step();
              if (i == n) begin
                chk_addr("R7", base + i - 1);
                chk("R7", int'(remain_o), 0);
                chk("R7", int'(busy_o), 0);
                chk("R7", int'(done_o), 1);
                @(negedge clk);
                chk("R7", int'(done_o), 0);
                break;
              end else if (base + i > 17) begin
                chk("R6", int'(range_err_o), 1);
                chk("R6", int'(busy_o), 0);
                chk("R6", int'(remain_o), n - i + 1);
                chk_addr("R6", base + i - 1);
                break;
              end else begin
                chk_addr("R3 R4 R5", base + i);
                chk("R3", int'(remain_o), n - i);
                chk("R7", int'(last_o), (n - i == 1) ? 1 : 0);
              end
            end
          end

    // R11 start clears range error (left set by last sweep transfer)
    chk("R11", int'(range_err_o), 1);
    pulse_start(1, 0, 0, 2);
    chk("R11", int'(range_err_o), 0);

    // R8 error freezes, later sector_done ignored
    step();
    @(negedge clk); err_i = 1; sec_done_i = 1;
    @(negedge clk); err_i = 0; sec_done_i = 0;
    chk("R8", int'(busy_o), 0);
    chk("R8", int'(sector_o), 2);
    chk("R8", int'(remain_o), 1);
    step();
    chk("R10", int'(sector_o), 2);
    chk("R10", int'(remain_o), 1);
    chk("R10", int'(done_o), 0);

    // R8 command end also freezes
    pulse_start(3, 1, 0, 4);
    @(negedge clk); cmd_end_i = 1;
    @(negedge clk); cmd_end_i = 0;
    chk("R8", int'(busy_o), 0);
    chk("R8", int'(remain_o), 4);
    chk("R8", int'(range_err_o), 0);

    // R9 initialise while busy ignored
    pulse_start(3, 0, 0, 3);
    pulse_init(5, 3, 9);
    chk("R9", int'(busy_o), 1);
    step();
    chk("R9", int'(sector_o), 1);
    chk("R9", int'(head_o), 1);
    step();
    step();
    chk("R9", int'(done_o), 1);

    // R4 R2 zero encodings: 256 sectors/track, one head, 2 cylinders, 256 count
    pulse_init(0, 0, 2);
    pulse_start(254, 0, 0, 0);
    chk("R2", int'(remain_o), 256);
    step(); chk("R4", int'(sector_o), 255);
    step(); chk("R4", int'(sector_o), 256);
    step();
    chk("R4", int'(sector_o), 1);
    chk("R5", int'(head_o), 0);
    chk("R5", int'(cyl_o), 1);
    chk("R3", int'(remain_o), 253);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule